// File: doc/BRIEF.md
# Complementary PWM Pair Output Stage

This block is the last stage between a set of PWM compare generators and six gate-drive outputs. The outputs are organised as three pairs: channels 0/1, 2/3 and 4/5. The even channel of a pair is the top side and the odd channel is the bottom side. Every pair is built the same way.

The source for each pair is picked first: its own generator, or generator 0 shared by all pairs. A pair then either routes its two raw compare signals straight through (independent mode), or builds a complementary pair from one selected signal, with a programmable dead band before every rising edge. After that come four stages in a fixed order: a software override per channel, a mask per channel, gating from two groups of fault lines, and a polarity inversion per side. Polarity is applied last, so a channel that is masked or faulted and has inverted polarity drives high.

Routing, source and correction selection, dead-band length and polarity are staged in shadow registers. They take effect only on a reload strobe given at the PWM period start. The override and mask inputs act at once. A fault disables outputs in the same cycle. The outputs stay disabled until the fault line is low, its group flag has been cleared, and a reload strobe has arrived.

Top module: `pwm_pair_stage`

## Requirements
- R1: With `multi_gen_i`=1 (after reload) pair p takes `raw_even_i[p]`/`raw_odd_i[p]`; with 0 every pair takes index 0 of both.
- R2: In complementary mode (`indep_i[p]`=0) with dead band 0, the odd channel of pair p is the inverse of the even channel, which is the selected source signal of the pair.
- R3: In independent mode (`indep_i[p]`=1) the even channel follows the raw even signal and the odd channel follows the raw odd signal, with no dead band.
- R4: In complementary mode each side's rising edge is delayed until its wanted level has been high for `dead_cycles_i` clock edges. A falling edge passes at once, so the two sides are never high together. A level that reverts before the count is reached produces no pulse.
- R5: `sw_ctl_i[c]`=1 replaces channel c's routed value by `sw_val_i[c]` in the same cycle, without reload.
- R6: `mask_i[c]`=1 forces channel c's pre-polarity value to 0 in the same cycle, without reload.
- R7: Polarity is the final stage: `top_neg_i[p]` inverts channel 2p and `bot_neg_i[p]` inverts channel 2p+1. With both bits and both masks of a pair set, both its outputs are 1.
- R8: Any of `fault_i[3:0]` high forces all six pre-polarity values to 0 in the same cycle.
- R9: Any of `fault_i[5:4]` high forces the odd channels' pre-polarity values to 0 in the same cycle and leaves the even channels untouched.
- R10: After a fault, a group stays disabled until its lines are low, its flag has been cleared by `fault_clr_i[g]` (bit 0 for lines 3..0, bit 1 for lines 5..4), and a later `reload_i` has been seen. Clearing one group does not release the other.
- R11: Correction code per pair `corr_sel_i[2p+1:2p]`: 00 uses the raw even signal; 01 uses raw odd when `corr_sw_i[p]`=1 and raw even otherwise; 1x uses raw odd when `dir_i[p]`=1 and raw even otherwise.
- R12: Changes of `multi_gen_i`, `indep_i`, `corr_sel_i`, `corr_sw_i`, `dead_cycles_i`, `top_neg_i` and `bot_neg_i` have no effect until `reload_i` is sampled high. All shadows reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | 1 | Period-start strobe; loads the shadows and releases faults |
| raw_even_i | input | 3 | Raw compare signal 0 of each generator |
| raw_odd_i | input | 3 | Raw compare signal 1 of each generator |
| dir_i | input | 3 | Current-polarity / count-direction signal per pair |
| multi_gen_i | input | 1 | 1: each pair uses its own generator |
| indep_i | input | 3 | Per-pair independent-mode select |
| corr_sel_i | input | 6 | Per-pair correction code, 2 bits each |
| corr_sw_i | input | 3 | Per-pair software source choice for code 01 |
| dead_cycles_i | input | 8 | Dead-band length in clock cycles |
| top_neg_i | input | 3 | Per-pair even-channel inversion |
| bot_neg_i | input | 3 | Per-pair odd-channel inversion |
| sw_ctl_i | input | 6 | Per-channel software override enable |
| sw_val_i | input | 6 | Per-channel software override value |
| mask_i | input | 6 | Per-channel mask |
| fault_i | input | 6 | Fault lines; 3..0 low group, 5..4 high group |
| fault_clr_i | input | 2 | Per-group fault flag clear |
| pwm_o | output | 6 | Drive outputs, channel c on bit c |

## Verification
The bench goes after the dead-band count boundary. A design that counts one edge short or one edge long moves the rising edge by a cycle. A design that does not restart the count lets a short reverting level through as a glitch. It checks that masked channels with inverted polarity come out high, which fails if polarity is applied before the mask. The fault release sequence is probed by a reload before the flag is cleared, and by a clear of the wrong group. A design that releases on either would let the outputs switch mid-period. Polarity changes made without a reload are checked to have no effect; an unshadowed polarity path would flip the outputs at once.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;

  typedef enum logic [1:0] {
    CORR_OFF  = 2'b00,
    CORR_SW   = 2'b01,
    CORR_DIR0 = 2'b10,
    CORR_DIR1 = 2'b11
  } corr_e;

  // Source picked for a complementary pair from the two compare signals.
  function automatic logic corr_pick(input corr_e code, input logic sw_sel,
                                     input logic dir, input logic cmp0,
                                     input logic cmp1);
    logic r;
    case (code)
      CORR_OFF:  r = cmp0;
      CORR_SW:   r = sw_sel ? cmp1 : cmp0;
      default:   r = dir ? cmp1 : cmp0;
    endcase
    return r;
  endfunction

  // Final stage for one channel: override, mask, fault gate, polarity.
  function automatic logic chan_finish(input logic routed, input logic ovr_en,
                                       input logic ovr_val, input logic msk,
                                       input logic kill, input logic neg);
    logic v;
    v = ovr_en ? ovr_val : routed;
    v = v & ~msk & ~kill;
    return v ^ neg;
  endfunction

endpackage

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bypass,
  input  logic            din,
  input  logic [DT_W-1:0] dt,
  output logic            dout
);
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] high_cnt;

  function automatic logic dt_open(input logic [DT_W-1:0] cnt,
                                   input logic [DT_W-1:0] lim);
    return cnt >= lim;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   high_cnt <= '0;
    else if (!din || bypass)      high_cnt <= '0;
    else if (high_cnt != CNT_MAX) high_cnt <= high_cnt + 1'b1;
  end

  assign dout = bypass ? din : (din & dt_open(high_cnt, dt));
endmodule

// File: rtl/pwm_pair_route.sv
module pwm_pair_route
  import pwm_stage_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp0,
  input  logic            cmp1,
  input  logic            indep,
  input  logic [1:0]      corr,
  input  logic            corr_sw,
  input  logic            dir,
  input  logic [DT_W-1:0] dt,
  output logic            out_top,
  output logic            out_bot
);
  logic pair_src;
  logic want_top;
  logic want_bot;

  assign pair_src = corr_pick(corr_e'(corr), corr_sw, dir, cmp0, cmp1);
  assign want_top = indep ? cmp0 : pair_src;
  assign want_bot = indep ? cmp1 : ~pair_src;

  pwm_deadband #(.DT_W(DT_W)) db_top_i (
    .clk(clk), .rst_n(rst_n), .bypass(indep), .din(want_top), .dt(dt),
    .dout(out_top)
  );

  pwm_deadband #(.DT_W(DT_W)) db_bot_i (
    .clk(clk), .rst_n(rst_n), .bypass(indep), .din(want_bot), .dt(dt),
    .dout(out_bot)
  );
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_any,
  input  logic clr,
  input  logic reload,
  output logic gate
);
  logic flag_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (fault_any)            flag_q <= 1'b1;
      else if (clr)             flag_q <= 1'b0;
      if (fault_any)            hold_q <= 1'b1;
      else if (reload && !flag_q) hold_q <= 1'b0;
    end
  end

  assign gate = fault_any | hold_q;
endmodule

// File: rtl/pwm_pair_stage.sv
module pwm_pair_stage
  import pwm_stage_pkg::*;
#(
  parameter int NPAIR   = 3,
  parameter int DT_W    = 8,
  parameter int NFLT    = 6,
  parameter int NFLT_LO = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reload_i,
  input  logic [NPAIR-1:0]     raw_even_i,
  input  logic [NPAIR-1:0]     raw_odd_i,
  input  logic [NPAIR-1:0]     dir_i,
  input  logic                 multi_gen_i,
  input  logic [NPAIR-1:0]     indep_i,
  input  logic [2*NPAIR-1:0]   corr_sel_i,
  input  logic [NPAIR-1:0]     corr_sw_i,
  input  logic [DT_W-1:0]      dead_cycles_i,
  input  logic [NPAIR-1:0]     top_neg_i,
  input  logic [NPAIR-1:0]     bot_neg_i,
  input  logic [2*NPAIR-1:0]   sw_ctl_i,
  input  logic [2*NPAIR-1:0]   sw_val_i,
  input  logic [2*NPAIR-1:0]   mask_i,
  input  logic [NFLT-1:0]      fault_i,
  input  logic [1:0]           fault_clr_i,
  output logic [2*NPAIR-1:0]   pwm_o
);
  localparam int NCH  = 2 * NPAIR;
  localparam int SH_W = 1 + NPAIR + NCH + NPAIR + DT_W + NPAIR + NPAIR;

  // Shadowed control set.
  logic [SH_W-1:0]  sh_d, sh_q;
  logic             multi_q;
  logic [NPAIR-1:0] indep_q, csw_q, tneg_q, bneg_q;
  logic [NCH-1:0]   corr_q;
  logic [DT_W-1:0]  dt_q;

  assign sh_d = {multi_gen_i, indep_i, corr_sel_i, corr_sw_i, dead_cycles_i,
                 top_neg_i, bot_neg_i};

  pwm_shadow_reg #(.W(SH_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .load(reload_i), .d(sh_d), .q(sh_q)
  );

  assign {multi_q, indep_q, corr_q, csw_q, dt_q, tneg_q, bneg_q} = sh_q;

  // Fault groups: index 0 gates every channel, index 1 gates odd channels.
  logic [1:0] fgate;
  logic       flt_lo_any, flt_hi_any;

  assign flt_lo_any = |fault_i[NFLT_LO-1:0];
  assign flt_hi_any = |fault_i[NFLT-1:NFLT_LO];

  pwm_fault_guard guard_lo_i (
    .clk(clk), .rst_n(rst_n), .fault_any(flt_lo_any), .clr(fault_clr_i[0]),
    .reload(reload_i), .gate(fgate[0])
  );

  pwm_fault_guard guard_hi_i (
    .clk(clk), .rst_n(rst_n), .fault_any(flt_hi_any), .clr(fault_clr_i[1]),
    .reload(reload_i), .gate(fgate[1])
  );

  // Per-pair routing and final stages; internal events named for checking.
  logic [NCH-1:0] routed;
  logic [NCH-1:0] pol_vec;
  logic [NCH-1:0] pre_pol;
  logic [NCH-1:0] kill;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic cmp0, cmp1;

    assign cmp0 = multi_q ? raw_even_i[p] : raw_even_i[0];
    assign cmp1 = multi_q ? raw_odd_i[p]  : raw_odd_i[0];

    pwm_pair_route #(.DT_W(DT_W)) route_i (
      .clk(clk), .rst_n(rst_n), .cmp0(cmp0), .cmp1(cmp1),
      .indep(indep_q[p]), .corr(corr_q[2*p+1:2*p]), .corr_sw(csw_q[p]),
      .dir(dir_i[p]), .dt(dt_q),
      .out_top(routed[2*p]), .out_bot(routed[2*p+1])
    );

    assign pol_vec[2*p]   = tneg_q[p];
    assign pol_vec[2*p+1] = bneg_q[p];
    assign kill[2*p]      = fgate[0];
    assign kill[2*p+1]    = fgate[0] | fgate[1];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign pre_pol[c] = chan_finish(routed[c], sw_ctl_i[c], sw_val_i[c],
                                    mask_i[c], kill[c], 1'b0);
    assign pwm_o[c]   = chan_finish(routed[c], sw_ctl_i[c], sw_val_i[c],
                                    mask_i[c], kill[c], pol_vec[c]);
  end

endmodule

// File: rtl/pwm_pair_stage_chk.sv
module pwm_pair_stage_chk #(
  parameter int NPAIR = 3,
  parameter int NCH   = 6,
  parameter int NFLT  = 6,
  parameter int NFLT_LO = 4,
  parameter int SH_W  = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reload_i,
  input logic [NFLT-1:0]  fault_i,
  input logic [NCH-1:0]   mask_i,
  input logic [NCH-1:0]   sw_ctl_i,
  input logic [NCH-1:0]   pwm_o,
  input logic [NCH-1:0]   pol_vec,
  input logic [NCH-1:0]   pre_pol,
  input logic [NPAIR-1:0] indep_q,
  input logic [SH_W-1:0]  sh_q,
  input logic [1:0]       fgate
);
  logic [NCH-1:0] odd_m;
  for (genvar c = 0; c < NCH; c++) begin : g_odd
    assign odd_m[c] = (c % 2) == 1;
  end

  // R6 / R7: a masked channel shows only its polarity level.
  p_mask_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_o ^ pol_vec) & mask_i) == '0);

  // R8: low fault group leaves only polarity levels on all channels.
  p_fault_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_i[NFLT_LO-1:0]) |-> (pwm_o == pol_vec));

  // R9: high fault group idles the odd channels.
  p_fault_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_i[NFLT-1:NFLT_LO]) |-> (((pwm_o ^ pol_vec) & odd_m) == '0));

  // R4: complementary sides never active together without override.
  for (genvar p = 0; p < NPAIR; p++) begin : g_ovl
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!indep_q[p] && !sw_ctl_i[2*p] && !sw_ctl_i[2*p+1])
        |-> !(pre_pol[2*p] && pre_pol[2*p+1]));
  end

  // R12: shadowed controls change only on a reload.
  p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> $stable(sh_q));

  // R10: a fault gate is released only by a reload.
  p_release_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fgate[0]) |-> $past(reload_i));
  p_release_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fgate[1]) |-> $past(reload_i));

endmodule

bind pwm_pair_stage pwm_pair_stage_chk #(
  .NPAIR(NPAIR), .NCH(NCH), .NFLT(NFLT), .NFLT_LO(NFLT_LO), .SH_W(SH_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .fault_i(fault_i),
  .mask_i(mask_i), .sw_ctl_i(sw_ctl_i), .pwm_o(pwm_o), .pol_vec(pol_vec),
  .pre_pol(pre_pol), .indep_q(indep_q), .sh_q(sh_q), .fgate(fgate)
);

// File: tb/pwm_pair_stage_tb_top.sv
module pwm_pair_stage_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reload_i = 1'b0;
  logic [2:0] raw_even_i = '0, raw_odd_i = '0, dir_i = '0;
  logic       multi_gen_i = 1'b0;
  logic [2:0] indep_i = '0, corr_sw_i = '0, top_neg_i = '0, bot_neg_i = '0;
  logic [5:0] corr_sel_i = '0, sw_ctl_i = '0, sw_val_i = '0, mask_i = '0;
  logic [7:0] dead_cycles_i = '0;
  logic [5:0] fault_i = '0;
  logic [1:0] fault_clr_i = '0;
  logic [5:0] pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwm_pair_stage dut_i (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .raw_even_i(raw_even_i),
    .raw_odd_i(raw_odd_i), .dir_i(dir_i), .multi_gen_i(multi_gen_i),
    .indep_i(indep_i), .corr_sel_i(corr_sel_i), .corr_sw_i(corr_sw_i),
    .dead_cycles_i(dead_cycles_i), .top_neg_i(top_neg_i),
    .bot_neg_i(bot_neg_i), .sw_ctl_i(sw_ctl_i), .sw_val_i(sw_val_i),
    .mask_i(mask_i), .fault_i(fault_i), .fault_clr_i(fault_clr_i),
    .pwm_o(pwm_o)
  );

  typedef struct packed {
    logic       mg;
    logic [2:0] ind;
    logic [5:0] cs;
    logic [2:0] csw;
    logic [2:0] dir;
    logic [2:0] re;
    logic [2:0] ro;
    logic [5:0] exp;
  } vec_t;

  // Routing vectors, dead band 0, polarity 0 (R1 R2 R3 R11).
  localparam vec_t VTAB [6] = '{
    '{1'b0, 3'b000, 6'b000000, 3'b000, 3'b000, 3'b001, 3'b000, 6'b010101},
    '{1'b1, 3'b000, 6'b000000, 3'b000, 3'b000, 3'b010, 3'b000, 6'b100110},
    '{1'b1, 3'b111, 6'b000000, 3'b000, 3'b000, 3'b101, 3'b011, 6'b011011},
    '{1'b0, 3'b010, 6'b000000, 3'b000, 3'b000, 3'b000, 3'b001, 6'b101010},
    '{1'b1, 3'b000, 6'b100101, 3'b001, 3'b100, 3'b111, 3'b000, 6'b100110},
    '{1'b1, 3'b000, 6'b100011, 3'b010, 3'b000, 3'b000, 3'b111, 6'b101010}
  };

  task automatic chk(input string tag, input logic [5:0] got,
                     input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_reload();
    reload_i = 1'b1;
    tick();
    reload_i = 1'b0;
  endtask

  task automatic apply_cfg(input logic mg, input logic [2:0] ind,
                           input logic [5:0] cs, input logic [2:0] csw,
                           input logic [7:0] dt, input logic [2:0] tn,
                           input logic [2:0] bn);
    multi_gen_i = mg; indep_i = ind; corr_sel_i = cs; corr_sw_i = csw;
    dead_cycles_i = dt; top_neg_i = tn; bot_neg_i = bn;
    pulse_reload();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 got=timeout exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R12 R2 reset state", pwm_o, 6'b101010);

    // Table walk
    for (int i = 0; i < 6; i++) begin
      raw_even_i = VTAB[i].re;
      raw_odd_i  = VTAB[i].ro;
      dir_i      = VTAB[i].dir;
      apply_cfg(VTAB[i].mg, VTAB[i].ind, VTAB[i].cs, VTAB[i].csw, 8'd0,
                3'b000, 3'b000);
      #1 chk($sformatf("R1 R2 R3 R11 vector %0d", i), pwm_o, VTAB[i].exp);
    end

    // R4: dead band of 3 cycles
    raw_even_i = 3'b000; raw_odd_i = 3'b000; dir_i = 3'b000;
    apply_cfg(1'b0, 3'b000, 6'b000000, 3'b000, 8'd3, 3'b000, 3'b000);
    repeat (5) tick();
    #1 chk("R4 settled", pwm_o, 6'b101010);
    @(negedge clk);
    raw_even_i = 3'b001;
    #1 chk("R4 both sides off at swap", pwm_o, 6'b000000);
    tick(); #1 chk("R4 edge 1", pwm_o, 6'b000000);
    tick(); #1 chk("R4 edge 2", pwm_o, 6'b000000);
    tick(); #1 chk("R4 edge 3 opens", pwm_o, 6'b010101);
    @(negedge clk);
    raw_even_i = 3'b000;
    #1 chk("R4 falling edge immediate", pwm_o, 6'b000000);
    tick();
    raw_even_i = 3'b001;
    #1 chk("R4 short level no pulse", pwm_o, 6'b000000);
    tick(); #1 chk("R4 short level swallowed", pwm_o, 6'b000000);
    raw_even_i = 3'b000;
    tick(); tick();
    #1 chk("R4 odd still closed", pwm_o, 6'b000000);
    tick(); #1 chk("R4 odd opens", pwm_o, 6'b101010);

    // Back to dead band 0
    apply_cfg(1'b0, 3'b000, 6'b000000, 3'b000, 8'd0, 3'b000, 3'b000);

    // R5: software override
    sw_ctl_i = 6'b000011; sw_val_i = 6'b000011;
    #1 chk("R5 override high", pwm_o, 6'b101011);
    sw_val_i = 6'b000000;
    #1 chk("R5 override low", pwm_o, 6'b101000);
    sw_ctl_i = 6'b000000;

    // R6: mask
    mask_i = 6'b100000;
    #1 chk("R6 mask channel 5", pwm_o, 6'b001010);
    mask_i = 6'b000000;

    // R12: polarity staged, R7: polarity last
    @(negedge clk);
    top_neg_i = 3'b001; bot_neg_i = 3'b001;
    #1 chk("R12 polarity no effect before reload", pwm_o, 6'b101010);
    tick(); #1 chk("R12 polarity still staged", pwm_o, 6'b101010);
    pulse_reload();
    #1 chk("R7 pair 0 inverted", pwm_o, 6'b101001);
    mask_i = 6'b000011;
    #1 chk("R7 masked inverted pair high", pwm_o, 6'b101011);
    mask_i = 6'b000000;
    apply_cfg(1'b0, 3'b000, 6'b000000, 3'b000, 8'd0, 3'b000, 3'b000);

    // R8 and R10: low fault group
    fault_i = 6'b000100;
    #1 chk("R8 low group same cycle", pwm_o, 6'b000000);
    tick();
    fault_i = 6'b000000;
    #1 chk("R10 held after line drops", pwm_o, 6'b000000);
    pulse_reload();
    #1 chk("R10 reload without clear", pwm_o, 6'b000000);
    fault_clr_i = 2'b01;
    tick();
    fault_clr_i = 2'b00;
    #1 chk("R10 cleared but no reload", pwm_o, 6'b000000);
    pulse_reload();
    #1 chk("R10 released at reload", pwm_o, 6'b101010);

    // R9 and R10: high fault group, even channel held by override
    sw_ctl_i = 6'b000001; sw_val_i = 6'b000001;
    #1 chk("R5 override before fault", pwm_o, 6'b101011);
    fault_i = 6'b100000;
    #1 chk("R9 high group gates odd only", pwm_o, 6'b000001);
    tick();
    fault_i = 6'b000000;
    fault_clr_i = 2'b01;
    tick();
    fault_clr_i = 2'b00;
    pulse_reload();
    #1 chk("R10 wrong group clear", pwm_o, 6'b000001);
    fault_clr_i = 2'b10;
    tick();
    fault_clr_i = 2'b00;
    pulse_reload();
    #1 chk("R10 high group released", pwm_o, 6'b101011);
    sw_ctl_i = 6'b000000; sw_val_i = 6'b000000;

    tick();
    finish_run();
  end
endmodule